// File: doc/BRIEF.md
# Dual-Bandwidth Bit Clock Recovery

This block recovers the bit clock of a sliced receive data stream. It runs on an oversampling clock of sixteen ticks per bit. A wrapping phase counter marks the middle of each bit with a one-tick strobe, and the received bit is captured at that point. A transition of the input between two ticks is the only thing that moves the phase. The phase count at that tick is the phase error.

The `acquire` input picks one of two loop laws. While it is high, the loop is in fast-pull mode: every transition removes half of the measured error, so a burst preamble is acquired within a few transitions. While it is low, the loop is in slow-pull mode: errors are summed over groups of four transitions, and each group moves the phase by at most one tick (1/16 bit), which keeps noisy edges from disturbing it. A lock flag with hysteresis reports whether the transitions fall near their expected place.

Top module: `bcr_clock_recovery`

## Requirements
- R1: During reset (synchronous, active-low `rst_n`) the phase count, transition memory, group state and lock counters clear. `bit_stb`, `bit_dat` and `locked` read 0.
- R2: The phase count advances by one per tick modulo 16. `bit_stb` is high exactly while the count equals 8. With no input transitions, strobes come exactly 16 ticks apart.
- R3: A transition is a tick where `rx_bit` differs from its value on the previous tick (0 after reset). Its error e is the phase count at that tick read as a signed value, -8..7. The next count is count + 1 - c, where c is the correction from R4 or R5. Ticks without a transition apply no correction.
- R4: With `acquire` = 1, c = e/2 rounded toward zero. From any starting offset on a clean 16-tick stream, `locked` is high no later than the 10th transition.
- R5: With `acquire` = 0, the errors of each group of four transitions are summed. The fourth transition applies c = +1 if the sum, including its own error, is positive; -1 if it is negative; 0 if it is zero. The other three apply c = 0. So strobe spacing stays within 15..17 ticks.
- R6: While `acquire` = 1, the group count and sum are held clear, so the first slow-pull group starts after `acquire` falls.
- R7: `locked` rises on the transition that completes 8 consecutive transitions with |e| <= 2.
- R8: `locked` falls on the transition that completes 4 consecutive transitions with |e| > 4. A transition with 2 < |e| <= 4 breaks both runs.
- R9: `bit_dat` takes the value of `rx_bit` at the tick where `bit_stb` is high, and holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16 ticks per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Sliced receive data, one sample per tick |
| acquire | input | 1 | 1 selects fast-pull mode, 0 selects slow-pull mode |
| bit_stb | output | 1 | One-tick strobe at bit centre |
| bit_dat | output | 1 | Received bit captured on the strobe |
| locked | output | 1 | Lock indication with hysteresis |

## Verification
`bit_stb` is decoded from the phase register, so a correction applied at the edge of a transition shows in the strobe during the tick after that edge. `bit_dat` changes at the edge that ends the strobe tick. `locked` changes at the edge of the decisive transition. The bench model updates its state at every rising edge from the same input the design sees. It compares all three outputs at the following falling edge, so each result is checked in the tick where it first becomes due. Directed checks add strobe-spacing limits per mode and the lock deadline counted in transitions.

// File: rtl/bcr_pkg.sv
// Package: shared types for the bit clock recovery block.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package bcr_pkg;

    // Loop bandwidth selected by the acquire input
    typedef enum logic {
        BW_NARROW = 1'b0,
        BW_WIDE   = 1'b1
    } bw_mode_e;

endpackage

// File: rtl/bcr_phase_gen.sv
// Module: bcr_phase_gen
// Wrapping phase counter of 2**PH_W ticks per bit. It decodes the bit-centre
// strobe at half the period and captures the data bit on the strobe.
// Assumes: corr is applied only when adj_en is high (a transition tick).
module bcr_phase_gen #(
    parameter int PH_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   adj_en,
    input  logic signed [PH_W-1:0] corr,
    input  logic                   rx_bit,
    output logic [PH_W-1:0]        phase,
    output logic                   bit_stb,
    output logic                   bit_dat
);
    localparam logic [PH_W-1:0] MID_PT = PH_W'(1) << (PH_W - 1);

    logic [PH_W-1:0] step;

    // Step size for this tick: one tick less the correction when adjusting
    always_comb begin
        step = PH_W'(1);
        if (adj_en) step = PH_W'(1) - $unsigned(corr);
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= '0;
        else        phase <= phase + step;
    end

    assign bit_stb = (phase == MID_PT);

    // Data capture at bit centre
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_dat <= 1'b0;
        else if (bit_stb) bit_dat <= rx_bit;
    end

    // R2: without a transition the phase advances by exactly one
    p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(adj_en)) |-> (phase == $past(phase) + PH_W'(1)));

    // R9: data only changes after a strobe tick
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_stb)) |-> $stable(bit_dat));

endmodule

// File: rtl/bcr_loop_filter.sv
// Module: bcr_loop_filter
// Turns the phase error of a transition into a phase correction. In fast-pull
// mode it returns half the error, rounded toward zero. In slow-pull mode it
// sums GROUP errors and returns a single +/-1 step on the last one.
// Assumes: err is only meaningful when xing is high.
module bcr_loop_filter
    import bcr_pkg::*;
#(
    parameter int PH_W  = 4,
    parameter int GROUP = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  bw_mode_e               mode,
    input  logic                   xing,
    input  logic signed [PH_W-1:0] err,
    output logic signed [PH_W-1:0] corr
);
    localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam int SW = PH_W + GW + 1;
    localparam logic [GW-1:0] LAST = GW'(GROUP - 1);

    logic [GW-1:0]          grp_cnt;
    logic signed [SW-1:0]   grp_sum;
    logic signed [SW-1:0]   total;
    logic signed [PH_W:0]   err_x;
    logic signed [PH_W:0]   half;
    logic signed [PH_W-1:0] corr_wide;
    logic signed [PH_W-1:0] corr_nar;

    // Fast-pull law: half the error, rounded toward zero
    always_comb begin
        err_x     = {err[PH_W-1], err};
        half      = err_x[PH_W] ? -((-err_x) >>> 1) : (err_x >>> 1);
        corr_wide = half[PH_W-1:0];
    end

    // Slow-pull law: sign of the group total on the last member
    always_comb begin
        total    = grp_sum + SW'(err);
        corr_nar = '0;
        if (xing && grp_cnt == LAST) begin
            if (total > 0)      corr_nar = PH_W'(1);
            else if (total < 0) corr_nar = -PH_W'(1);
        end
    end

    assign corr = (mode == BW_WIDE) ? corr_wide : corr_nar;

    // Group counter and running sum, held clear in fast-pull mode
    always_ff @(posedge clk) begin
        if (!rst_n || mode == BW_WIDE) begin
            grp_cnt <= '0;
            grp_sum <= '0;
        end else if (xing) begin
            if (grp_cnt == LAST) begin
                grp_cnt <= '0;
                grp_sum <= '0;
            end else begin
                grp_cnt <= grp_cnt + GW'(1);
                grp_sum <= total;
            end
        end
    end

    // R5: slow-pull correction never exceeds one tick
    p_narrow_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == BW_NARROW) |-> (corr >= -1 && corr <= 1));

    // R6: group state is clear after any fast-pull tick
    p_group_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode) == BW_WIDE) |-> (grp_cnt == '0 && grp_sum == '0));

endmodule

// File: rtl/bcr_lock_det.sv
// Module: bcr_lock_det
// Hysteretic lock flag. It sets after GOOD_RUN consecutive small-error
// transitions and clears after BAD_RUN consecutive large-error transitions.
// Assumes: err is sampled only on ticks where xing is high.
module bcr_lock_det #(
    parameter int PH_W     = 4,
    parameter int GOOD_RUN = 8,
    parameter int BAD_RUN  = 4,
    parameter int GOOD_TOL = 2,
    parameter int BAD_TOL  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xing,
    input  logic signed [PH_W-1:0] err,
    output logic                   locked
);
    localparam int GCW = $clog2(GOOD_RUN + 1);
    localparam int BCW = $clog2(BAD_RUN + 1);
    localparam logic [GCW-1:0] G_TOP = GCW'(GOOD_RUN);
    localparam logic [BCW-1:0] B_TOP = BCW'(BAD_RUN);
    localparam logic [PH_W:0]  G_LIM = (PH_W + 1)'(GOOD_TOL);
    localparam logic [PH_W:0]  B_LIM = (PH_W + 1)'(BAD_TOL);

    logic [PH_W:0]    mag;
    logic [GCW-1:0]   good_cnt;
    logic [BCW-1:0]   bad_cnt;
    logic [GCW-1:0]   good_nxt;
    logic [BCW-1:0]   bad_nxt;

    // Error magnitude and saturating run increments
    always_comb begin
        mag      = err[PH_W-1] ? -{1'b1, err} : {1'b0, err};
        good_nxt = (good_cnt == G_TOP) ? good_cnt : good_cnt + GCW'(1);
        bad_nxt  = (bad_cnt == B_TOP) ? bad_cnt : bad_cnt + BCW'(1);
    end

    // Run counters and lock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_cnt <= '0;
            bad_cnt  <= '0;
            locked   <= 1'b0;
        end else if (xing) begin
            if (mag <= G_LIM) begin
                good_cnt <= good_nxt;
                if (good_nxt == G_TOP) locked <= 1'b1;
            end else begin
                good_cnt <= '0;
            end
            if (mag > B_LIM) begin
                bad_cnt <= bad_nxt;
                if (bad_nxt == B_TOP) locked <= 1'b0;
            end else begin
                bad_cnt <= '0;
            end
        end
    end

    // R7: lock can only rise on a transition tick
    p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(locked)) |-> $past(xing));

    // R8: lock can only fall on a transition tick
    p_lock_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(locked)) |-> $past(xing));

endmodule

// File: rtl/bcr_clock_recovery.sv
// Module: bcr_clock_recovery (top)
// Dual-bandwidth bit clock recovery from input transitions. It detects
// transitions, reads the phase error and routes it to the loop filter and
// the lock detector.
// Assumes: rx_bit is already synchronous to clk, 2**PH_W ticks per bit.
module bcr_clock_recovery
    import bcr_pkg::*;
#(
    parameter int PH_W     = 4,
    parameter int GROUP    = 4,
    parameter int GOOD_RUN = 8,
    parameter int BAD_RUN  = 4,
    parameter int GOOD_TOL = 2,
    parameter int BAD_TOL  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic acquire,
    output logic bit_stb,
    output logic bit_dat,
    output logic locked
);
    logic                   rx_q;
    logic                   xing;
    logic [PH_W-1:0]        phase;
    logic signed [PH_W-1:0] err;
    logic signed [PH_W-1:0] corr;
    bw_mode_e               mode;

    // Previous input sample for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b0;
        else        rx_q <= rx_bit;
    end

    assign xing = rx_bit ^ rx_q;
    assign err  = signed'(phase);
    assign mode = acquire ? BW_WIDE : BW_NARROW;

    bcr_phase_gen #(.PH_W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .adj_en(xing), .corr(corr),
        .rx_bit(rx_bit), .phase(phase), .bit_stb(bit_stb), .bit_dat(bit_dat)
    );

    bcr_loop_filter #(.PH_W(PH_W), .GROUP(GROUP)) u_filter (
        .clk(clk), .rst_n(rst_n), .mode(mode), .xing(xing),
        .err(err), .corr(corr)
    );

    bcr_lock_det #(
        .PH_W(PH_W), .GOOD_RUN(GOOD_RUN), .BAD_RUN(BAD_RUN),
        .GOOD_TOL(GOOD_TOL), .BAD_TOL(BAD_TOL)
    ) u_lock (
        .clk(clk), .rst_n(rst_n), .xing(xing), .err(err), .locked(locked)
    );

    // R3: the phase is corrected only on a transition tick
    p_adjust_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rx_bit) == $past(rx_q)) |->
        (phase == $past(phase) + PH_W'(1)));

endmodule

// File: tb/tb_bcr_clock_recovery.sv
module tb_bcr_clock_recovery;
    localparam int PERIOD = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic acquire = 1'b1;
    logic bit_stb, bit_dat, locked;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    bcr_clock_recovery dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .acquire(acquire),
        .bit_stb(bit_stb), .bit_dat(bit_dat), .locked(locked)
    );

    // Behavioural reference state
    int m_ph = 0, m_prev = 0, m_dat = 0, m_lock = 0;
    int m_good = 0, m_bad = 0, m_gc = 0, m_gsum = 0;
    int xcount = 0;

    always @(posedge clk) begin
        int x, e, c, ae, tot;
        cyc++;
        if (!rst_n) begin
            m_ph = 0; m_prev = 0; m_dat = 0; m_lock = 0;
            m_good = 0; m_bad = 0; m_gc = 0; m_gsum = 0;
        end else begin
            x = (int'(rx_bit) != m_prev);
            e = (m_ph >= PERIOD / 2) ? m_ph - PERIOD : m_ph;
            c = 0;
            if (acquire) begin
                m_gc = 0; m_gsum = 0;
                if (x) c = e / 2;
            end else if (x) begin
                if (m_gc == 3) begin
                    tot = m_gsum + e;
                    c = (tot > 0) ? 1 : (tot < 0) ? -1 : 0;
                    m_gc = 0; m_gsum = 0;
                end else begin
                    m_gsum += e; m_gc++;
                end
            end
            if (x) begin
                xcount++;
                ae = (e < 0) ? -e : e;
                if (ae <= 2) begin
                    if (m_good < 8) m_good++;
                    if (m_good == 8) m_lock = 1;
                end else m_good = 0;
                if (ae > 4) begin
                    if (m_bad < 4) m_bad++;
                    if (m_bad == 4) m_lock = 0;
                end else m_bad = 0;
            end
            if (m_ph == PERIOD / 2) m_dat = int'(rx_bit);
            m_ph = ((m_ph + 1 - c) % PERIOD + PERIOD) % PERIOD;
            m_prev = int'(rx_bit);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-tick comparison with the model, plus strobe spacing checks
    int sp_mode = 0;      // 0 none, 1 slow-pull spacing, 2 exact spacing
    int last_stb = -1;
    int lock_xc = -1;
    bit track_lock = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2/R3 bit_stb", int'(bit_stb), int'(m_ph == PERIOD / 2));
            check("R9 bit_dat", int'(bit_dat), m_dat);
            check("R7/R8 locked", int'(locked), m_lock);
            if (track_lock && locked && lock_xc < 0) lock_xc = xcount;
            if (bit_stb) begin
                if (last_stb >= 0 && sp_mode == 1) begin
                    n_chk++;
                    if (cyc - last_stb < 15 || cyc - last_stb > 17) begin
                        n_fail++;
                        $display("FAIL R5 spacing: actual %0d expected 15..17", cyc - last_stb);
                    end
                end
                if (last_stb >= 0 && sp_mode == 2)
                    check("R2 spacing", cyc - last_stb, PERIOD);
                last_stb = cyc;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    logic [15:0] lf = 16'hACE1;
    function automatic logic [15:0] lf_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic hold(input logic b, input int len);
        rx_bit = b;
        repeat (len) @(negedge clk);
    endtask

    task automatic rand_bits(input int n, input int jit);
        int pj = 0;
        for (int i = 0; i < n; i++) begin
            int j;
            lf = lf_next(lf);
            j = jit ? int'(lf[6:4] % 5) - 2 : 0;
            hold(lf[0], PERIOD + j - pj);
            pj = j;
        end
        hold(rx_bit, PERIOD - pj);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 bit_stb", int'(bit_stb), 0);
        check("R1 bit_dat", int'(bit_dat), 0);
        check("R1 locked", int'(locked), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: fast-pull acquisition from an offset, 1100 preamble then data
        track_lock = 1;
        hold(1'b0, 5);
        xcount = 0;
        for (int i = 0; i < 4; i++) begin
            hold(1'b1, 2 * PERIOD);
            hold(1'b0, 2 * PERIOD);
        end
        rand_bits(30, 0);
        n_chk++;
        if (lock_xc < 1 || lock_xc > 10) begin
            n_fail++;
            $display("FAIL R4 lock deadline: actual %0d expected 1..10", lock_xc);
        end
        check("R7 locked after preamble", int'(locked), 1);
        track_lock = 0;
        // R5/R6: slow-pull with jittered edges
        acquire = 1'b0;
        last_stb = -1; sp_mode = 1;
        rand_bits(80, 1);
        // R8: phase jump of half a bit, lock must drop
        hold(~rx_bit, PERIOD + PERIOD / 2);
        rand_bits(20, 0);
        check("R8 locked after jump", int'(locked), 0);
        // R2: no transitions, exact spacing
        sp_mode = 0; last_stb = -1;
        hold(rx_bit, 4); sp_mode = 2;
        hold(rx_bit, 8 * PERIOD);
        sp_mode = 0;
        // R6/R7: back to fast-pull, relock
        acquire = 1'b1;
        rand_bits(40, 0);
        check("R7 relock", int'(locked), 1);
        // R6: short fast-pull pulse between slow-pull groups
        acquire = 1'b0;
        rand_bits(6, 1);
        acquire = 1'b1;
        @(negedge clk);
        acquire = 1'b0;
        rand_bits(20, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule